// File: doc/BRIEF.md
# Debug Port Access Lock Controller

This block decides whether an external debug port and a serial bootloader port may reach the device. It keeps a protection level that models non-volatile fuse state. The level can only be raised by lock commands. The one exception is a single authenticated path that lowers it again. Either port can authenticate by sending a fixed-length password, which is compared word by word against a stored key. Each port's grant depends on the current level and on which port has authenticated.

There are four levels. At the open level, a check from either port opens the debug port. At the password level, the debug port opens only after the debug port itself passes the check. At the fused level, the debug port is closed and only the bootloader can get in. An authenticated bootloader session at this level may move the device back to the password level. At the sealed level, every port is shut for good and password words are ignored.

The level register is cleared only by the power-on reset. A soft reset clears the authentication state, so both grants stay low until a new check passes.

Top module: `dbg_access_lock`

## Requirements
- R1: While rst_n or por_n is low, and in the first cycle after release, both grants and pw_err are low. A soft reset (rst_n alone) leaves lock_level unchanged. Only por_n returns lock_level to 0.
- R2: A password is NWORDS consecutive words sent on pw_word with pw_valid high, all from the same port (pw_src 0 = debug, 1 = bootloader). Word i is compared with key_store bits [16*i+15:16*i]. A full match marks that port authenticated, and its effect on the grants is visible in the cycle after the last word.
- R3: A word that does not match its key word, or a word that comes from the other port in the middle of a sequence, aborts the check. It clears the authentication of the port that sent the word and sets pw_err, which stays set until the next reset.
- R4: lock_level reports the level: 0 open, 1 password, 2 fused, 3 sealed.
- R5: When cmd_valid is high, command code 1 raises the level to 1 and code 2 raises it to 2. Code 3 moves the level from 2 to 3. A command that would not raise the level is ignored, and code 3 is ignored at any level other than 2.
- R6: At level 0, dbg_grant is high once either port has authenticated, and boot_grant is high once the bootloader has authenticated.
- R7: At level 1, dbg_grant is high only after the debug port has authenticated. boot_grant still follows bootloader authentication.
- R8: At level 2, dbg_grant is low. boot_grant is high only after bootloader authentication.
- R9: Command code 0 at level 2, with the bootloader authenticated, moves the level to 1. Code 0 is ignored in every other case. After this move, the debug port must pass its own check before dbg_grant rises.
- R10: At level 3, both grants are low. Password words are ignored: pw_err does not change and pw_busy stays low.
- R11: Any change of level drops the debug port's authentication, so an open debug grant closes in the cycle after a raising command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the level and everything else |
| rst_n | input | 1 | Soft reset, active low; clears authentication and the error flag |
| key_store | input | NWORDS*WORD_W | Stored password, word 0 in the low bits |
| pw_valid | input | 1 | A password word is present |
| pw_src | input | 1 | Port of the word: 0 debug, 1 bootloader |
| pw_word | input | WORD_W | Password word |
| cmd_valid | input | 1 | A command is present |
| cmd_code | input | 2 | 0 reopen, 1 password lock, 2 blow fuse, 3 disable bootloader |
| dbg_grant | output | 1 | Debug port access granted |
| boot_grant | output | 1 | Bootloader access granted |
| lock_level | output | 2 | Current protection level |
| pw_err | output | 1 | Sticky failed-attempt flag |
| pw_busy | output | 1 | A password sequence is in progress |

## Verification
The assertions check on every cycle that the level never falls except right after a valid reopen event, that the error flag stays set, that the fused and sealed levels keep their ports closed, and that a rising debug grant at the password level follows a debug-port match. Only the bench's scenarios can show the rest. That covers a soft reset keeping the level, each grant opening after exactly NWORDS words, a mismatch or a port switch aborting at the right word, weaker commands being ignored, and reopen needing bootloader authentication. These sequences come from random stimulus checked against a level and authentication model in the bench, plus directed corner cases.

// File: rtl/dal_pkg.sv
package dal_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_PWLOCK = 2'd1,
    LVL_FUSED  = 2'd2,
    LVL_SEALED = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    CMD_REOPEN = 2'd0,
    CMD_PWLOCK = 2'd1,
    CMD_FUSE   = 2'd2,
    CMD_SEAL   = 2'd3
  } cmd_e;

  localparam logic SRC_DBG  = 1'b0;
  localparam logic SRC_BOOT = 1'b1;

  // Level after a command; weaker targets are refused except the reopen path.
  function automatic lvl_e next_level(lvl_e cur, cmd_e c, logic boot_ok);
    lvl_e r;
    r = cur;
    case (c)
      CMD_PWLOCK: if (cur == LVL_OPEN) r = LVL_PWLOCK;
      CMD_FUSE:   if (cur == LVL_OPEN || cur == LVL_PWLOCK) r = LVL_FUSED;
      CMD_SEAL:   if (cur == LVL_FUSED) r = LVL_SEALED;
      default:    if (cur == LVL_FUSED && boot_ok) r = LVL_PWLOCK;
    endcase
    return r;
  endfunction

  function automatic logic dbg_allowed(lvl_e l, logic dbg_ok, logic boot_ok);
    case (l)
      LVL_OPEN:   return dbg_ok | boot_ok;
      LVL_PWLOCK: return dbg_ok;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic boot_allowed(lvl_e l, logic boot_ok);
    return (l != LVL_SEALED) && boot_ok;
  endfunction

endpackage

// File: rtl/dal_pw_check.sv
module dal_pw_check
  import dal_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [NWORDS*WORD_W-1:0] key_store,
  input  logic                     pw_valid,
  input  logic                     pw_src,
  input  logic [WORD_W-1:0]        pw_word,
  output logic                     ev_ok,
  output logic                     ev_fail,
  output logic                     busy
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0]  idx;
  logic              src_q;
  logic [WORD_W-1:0] exp_word;
  logic              take, word_bad;

  assign exp_word = key_store[idx*WORD_W +: WORD_W];
  assign take     = enable && pw_valid;
  assign word_bad = (pw_word != exp_word) || (busy && pw_src != src_q);
  assign ev_fail  = take && word_bad;
  assign ev_ok    = take && !word_bad && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      busy  <= 1'b0;
      src_q <= SRC_DBG;
    end else if (!enable || ev_fail || ev_ok) begin
      idx  <= '0;
      busy <= 1'b0;
    end else if (take) begin
      idx  <= idx + 1'b1;
      busy <= 1'b1;
      if (!busy) src_q <= pw_src;
    end
  end
endmodule

// File: rtl/dal_level_reg.sv
module dal_level_reg
  import dal_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       boot_auth,
  output lvl_e       level,
  output logic       changed,
  output logic       to_sealed,
  output logic       reopen_ok
);
  lvl_e nxt;

  always_comb begin
    nxt       = cmd_valid ? next_level(level, cmd_e'(cmd_code), boot_auth) : level;
    changed   = (nxt != level);
    to_sealed = changed && (nxt == LVL_SEALED);
    reopen_ok = cmd_valid && (cmd_e'(cmd_code) == CMD_REOPEN) &&
                (level == LVL_FUSED) && boot_auth;
  end

  // Models fuse state: only the power-on reset clears it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) level <= LVL_OPEN;
    else        level <= nxt;
  end
endmodule

// File: rtl/dal_auth.sv
module dal_auth
  import dal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_ok,
  input  logic ev_fail,
  input  logic ev_src,
  input  logic lvl_changed,
  input  logic to_sealed,
  output logic dbg_auth,
  output logic boot_auth
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_auth  <= 1'b0;
      boot_auth <= 1'b0;
    end else begin
      if (ev_ok && ev_src == SRC_DBG)    dbg_auth  <= 1'b1;
      if (ev_ok && ev_src == SRC_BOOT)   boot_auth <= 1'b1;
      if (ev_fail && ev_src == SRC_DBG)  dbg_auth  <= 1'b0;
      if (ev_fail && ev_src == SRC_BOOT) boot_auth <= 1'b0;
      if (lvl_changed) dbg_auth  <= 1'b0;
      if (to_sealed)   boot_auth <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_access_lock.sv
module dbg_access_lock
  import dal_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     rst_n,
  input  logic [NWORDS*WORD_W-1:0] key_store,
  input  logic                     pw_valid,
  input  logic                     pw_src,
  input  logic [WORD_W-1:0]        pw_word,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_code,
  output logic                     dbg_grant,
  output logic                     boot_grant,
  output logic [1:0]               lock_level,
  output logic                     pw_err,
  output logic                     pw_busy
);
  logic soft_n;
  lvl_e level;
  logic ev_ok, ev_fail, ev_ok_dbg;
  logic lvl_changed, to_sealed, reopen_ok;
  logic dbg_auth, boot_auth;

  assign soft_n    = rst_n && por_n;
  assign ev_ok_dbg = ev_ok && (pw_src == SRC_DBG);

  dal_pw_check #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_check (
    .clk(clk), .rst_n(soft_n), .enable(level != LVL_SEALED),
    .key_store(key_store), .pw_valid(pw_valid), .pw_src(pw_src),
    .pw_word(pw_word), .ev_ok(ev_ok), .ev_fail(ev_fail), .busy(pw_busy)
  );

  dal_level_reg u_level (
    .clk(clk), .por_n(por_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .boot_auth(boot_auth), .level(level), .changed(lvl_changed),
    .to_sealed(to_sealed), .reopen_ok(reopen_ok)
  );

  dal_auth u_auth (
    .clk(clk), .rst_n(soft_n), .ev_ok(ev_ok), .ev_fail(ev_fail),
    .ev_src(pw_src), .lvl_changed(lvl_changed), .to_sealed(to_sealed),
    .dbg_auth(dbg_auth), .boot_auth(boot_auth)
  );

  always_ff @(posedge clk or negedge soft_n) begin
    if (!soft_n)      pw_err <= 1'b0;
    else if (ev_fail) pw_err <= 1'b1;
  end

  assign lock_level = level;
  assign dbg_grant  = dbg_allowed(level, dbg_auth, boot_auth);
  assign boot_grant = boot_allowed(level, boot_auth);
endmodule

// File: rtl/dbg_access_lock_chk.sv
module dbg_access_lock_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic [1:0] lock_level,
  input logic       dbg_grant,
  input logic       boot_grant,
  input logic       pw_err,
  input logic       pw_busy,
  input logic       reopen_ok,
  input logic       ev_ok_dbg
);
  // R5
  level_monotone_chk: assert property (@(posedge clk) disable iff (!por_n)
    (lock_level < $past(lock_level)) |-> $past(reopen_ok));

  // R9
  reopen_target_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(reopen_ok) |-> lock_level == 2'd1);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $past(pw_err) |-> pw_err);

  // R8
  fused_dbg_closed_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock_level == 2'd2 |-> !dbg_grant);

  // R10
  sealed_closed_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock_level == 2'd3 |-> (!dbg_grant && !boot_grant && !pw_busy));

  // R10
  sealed_err_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (lock_level == 2'd3 && $past(lock_level) == 2'd3) |-> $stable(pw_err));

  // R7
  pwlock_dbg_source_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ($rose(dbg_grant) && lock_level == 2'd1) |-> $past(ev_ok_dbg));

  // R1
  reset_closed_chk: assert property (@(posedge clk)
    (!rst_n || !por_n) |=> (!dbg_grant && !boot_grant && !pw_err));
endmodule

bind dbg_access_lock dbg_access_lock_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .lock_level(lock_level),
  .dbg_grant(dbg_grant), .boot_grant(boot_grant), .pw_err(pw_err),
  .pw_busy(pw_busy), .reopen_ok(reopen_ok), .ev_ok_dbg(ev_ok_dbg)
);

// File: tb/test_dbg_access_lock.sv
`timescale 1ns/1ps
module test_dbg_access_lock;
  localparam int NW = 4;
  localparam int WW = 16;
  localparam logic [NW*WW-1:0] KEY = 64'hA5C3_1E7F_90B2_4D68;

  logic clk = 1'b0;
  logic por_n, rst_n, pw_valid, pw_src, cmd_valid;
  logic [WW-1:0] pw_word;
  logic [1:0] cmd_code;
  logic dbg_grant, boot_grant, pw_err, pw_busy;
  logic [1:0] lock_level;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // bench model state
  int m_lvl;
  bit m_da, m_ba, m_err;

  always #4 clk = ~clk;

  dbg_access_lock #(.NWORDS(NW), .WORD_W(WW)) i_dbg_access_lock (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .key_store(KEY),
    .pw_valid(pw_valid), .pw_src(pw_src), .pw_word(pw_word),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .dbg_grant(dbg_grant),
    .boot_grant(boot_grant), .lock_level(lock_level), .pw_err(pw_err),
    .pw_busy(pw_busy)
  );

  function automatic bit exp_dbg(int l, bit da, bit ba);
    if (l == 0) return da || ba;
    if (l == 1) return da;
    return 1'b0;
  endfunction

  function automatic bit exp_boot(int l, bit ba);
    return (l != 3) && ba;
  endfunction

  function automatic string lvl_tag(int l);
    case (l)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string rq);
    chk(rq, "lock_level R4", lock_level, m_lvl);
    chk(lvl_tag(m_lvl), "dbg_grant", dbg_grant, exp_dbg(m_lvl, m_da, m_ba));
    chk(lvl_tag(m_lvl), "boot_grant", boot_grant, exp_boot(m_lvl, m_ba));
    chk(rq, "pw_err", pw_err, m_err);
    chk(rq, "pw_busy", pw_busy, 0);
  endtask

  task automatic do_reset(input bit power);
    @(negedge clk);
    rst_n = 0;
    if (power) por_n = 0;
    @(negedge clk);
    chk("R1", "dbg_grant in reset", dbg_grant, 0);
    chk("R1", "boot_grant in reset", boot_grant, 0);
    @(negedge clk);
    rst_n = 1; por_n = 1;
    m_da = 0; m_ba = 0; m_err = 0;
    if (power) m_lvl = 0;
    @(negedge clk);
    check_all("R1");
  endtask

  // Sends a password; bad_at < NW corrupts that word; switch_at < NW sends it from the other port.
  task automatic send_pw(input bit src, input int bad_at, input int switch_at);
    bit fail_src;
    bit failed = 0;
    for (int i = 0; i < NW; i++) begin
      pw_valid = 1;
      pw_src   = (i == switch_at) ? ~src : src;
      pw_word  = KEY[i*WW +: WW] ^ ((i == bad_at) ? 16'h0100 : 16'h0000);
      fail_src = pw_src;
      @(negedge clk);
      pw_valid = 0;
      if (i == bad_at || i == switch_at) begin
        failed = 1;
        break;
      end
    end
    if (m_lvl != 3) begin
      if (failed) begin
        m_err = 1;
        if (fail_src) m_ba = 0; else m_da = 0;
      end else begin
        if (src) m_ba = 1; else m_da = 1;
      end
    end
  endtask

  task automatic send_cmd(input int code);
    int nl;
    cmd_valid = 1; cmd_code = code[1:0];
    @(negedge clk);
    cmd_valid = 0;
    nl = m_lvl;
    case (code)
      1: if (m_lvl < 1) nl = 1;
      2: if (m_lvl < 2) nl = 2;
      3: if (m_lvl == 2) nl = 3;
      default: if (m_lvl == 2 && m_ba) nl = 1;
    endcase
    if (nl != m_lvl) begin
      m_da = 0;
      if (nl == 3) m_ba = 0;
    end
    m_lvl = nl;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int r;
    por_n = 0; rst_n = 0; pw_valid = 0; pw_src = 0; pw_word = '0;
    cmd_valid = 0; cmd_code = '0;
    m_lvl = 0; m_da = 0; m_ba = 0; m_err = 0;
    r = $urandom(32'd20240611);
    do_reset(1);

    // R1: open level still needs a check after reset; R2: debug check opens it
    send_pw(0, NW, NW);   check_all("R2");
    // R11: raising drops the debug grant
    send_cmd(1);          check_all("R11");
    // R5: weaker command ignored
    send_cmd(0);          check_all("R5");
    send_cmd(3);          check_all("R5");
    // R3: mismatch at last word
    send_pw(0, NW-1, NW); check_all("R3");
    send_pw(0, NW, NW);   check_all("R7");
    send_pw(1, NW, NW);   check_all("R7");
    // R3: port switch mid-sequence
    send_pw(0, NW, 2);    check_all("R3");
    send_cmd(2);          check_all("R8");
    // R1: soft reset keeps the fuse level
    do_reset(0);
    // R9: reopen without bootloader auth ignored, then with auth accepted
    send_cmd(0);          check_all("R9");
    send_pw(1, NW, NW);   check_all("R8");
    send_cmd(0);          check_all("R9");
    send_pw(0, NW, NW);   check_all("R9");
    send_cmd(2);          check_all("R5");
    send_cmd(3);          check_all("R10");
    // R10: words ignored when sealed
    send_pw(1, 0, NW);    check_all("R10");
    send_pw(1, NW, NW);   check_all("R10");
    do_reset(1);

    for (int it = 0; it < 400; it++) begin
      r = $urandom % 16;
      if (r < 6)        send_pw($urandom % 2, NW, NW);
      else if (r < 8)   send_pw($urandom % 2, $urandom % NW, NW);
      else if (r < 11)  send_cmd($urandom % 3);
      else if (r == 11) send_cmd(3);
      else if (r == 12) begin do_reset(0); continue; end
      else if (r == 13) begin do_reset(1); continue; end
      else              send_pw($urandom % 2, NW, 1 + ($urandom % (NW-1)));
      check_all("R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule